// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs a repeating measurement cycle of four phases. The phases are offset cancellation (auto-zero), signal integration, reference de-integration and integrator discharge (zero-integrate). While each phase runs, the block holds exactly one phase-enable output high. These enables drive the analog switch network. The integrator, the comparator and the switches are outside the block. Its only analog-side input is the comparator output, which it synchronises before use.

Time is measured in counts. One count is `DIV` clock pulses. Signal integration lasts a fixed number of counts. At the end of signal integration, the synchronised comparator level is stored as the polarity. De-integration then counts until the comparator departs from that level, or until the count reaches its full-scale limit, which is reported as overrange. When de-integration ends, the count, the sign and the overrange flag are registered, and a one-cycle strobe marks them. Zero-integrate then has a bounded length in clocks, and a longer fixed length after an overrange. Auto-zero fills the rest of the cycle, so the distance between successive integration starts never changes.

Reset is asynchronous and active low. Its deassertion is assumed to be synchronous to `clk`.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is asserted, `phase_en` is 4'b0001 (auto-zero only), and `reading`, `negative`, `overrange` and `reading_valid` are all 0.
- R2: `phase_en` is always one-hot. Bit 0 is auto-zero, bit 1 is signal integrate, bit 2 is de-integrate and bit 3 is zero-integrate. Phases advance only in the order bit 0 → 1 → 2 → 3 → 0.
- R3: Signal integrate lasts exactly `INT_COUNTS*DIV` clocks.
- R4: The synchronised comparator level at the end of signal integrate sets the sign. A level of 1 gives `negative`=0 and a level of 0 gives `negative`=1. Comparator activity after that point does not change `negative` until the next result.
- R5: The comparator passes through a 2-flop synchroniser. If the comparator leaves the stored polarity level during clock w of de-integrate (the first clock is w=0), de-integrate lasts w+3 clocks and `reading` = floor((w+2)/`DIV`), with `overrange`=0. This holds whenever w+3 ≤ `DEINT_MAX*DIV`. If the comparator change and the last count arrive on the same edge, the comparator change wins.
- R6: If de-integrate reaches `DEINT_MAX` counts with no comparator change, it ends after exactly `DEINT_MAX*DIV` clocks, with `reading`=`DEINT_MAX` and `overrange`=1.
- R7: `reading_valid` is high for exactly one clock: the first clock of zero-integrate. `reading`, `negative` and `overrange` change only on the edge that raises `reading_valid`.
- R8: After a normal result, zero-integrate lasts `ZI_NORM` clocks if the synchronised comparator does not change.
- R9: After a normal result, a comparator change during clock w of zero-integrate ends the phase after w+3 clocks. If w+3 is below `ZI_MIN`, the change is ignored and the `ZI_NORM` limit applies.
- R10: After an overrange result, zero-integrate lasts exactly `ZI_EXT` clocks, whatever the comparator does.
- R11: Successive starts of signal integrate are exactly `CYCLE_COUNTS*DIV` clocks apart. Auto-zero takes whatever time the other phases leave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Raw comparator output (asynchronous) |
| phase_en | output | 4 | One-hot phase enables: 0 auto-zero, 1 integrate, 2 de-integrate, 3 zero-integrate |
| reading | output | RES_W | De-integrate count of the last conversion |
| negative | output | 1 | Sign of the last conversion, 1 for a negative input |
| overrange | output | 1 | Last conversion hit the full-scale limit |
| reading_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Conversions are driven with both comparator polarities.

For de-integrate, the comparator is flipped at offsets chosen for specific purposes:
- Some offsets land on count boundaries and some fall between them, which separates exact counting from off-by-one rounding.
- One offset lands on the same edge as the last count, to show that the comparator takes priority.
- One offset falls a single clock past full scale, and some runs never flip, so the overrange path is taken both ways.

For zero-integrate, the comparator is held steady, flipped before the minimum, flipped after it, and toggled during an extended phase. These cases tell the normal limit, the early exit, the minimum and the overrange stretch apart.

Phase lengths and the fixed cycle period are measured on every conversion.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DI  = 2'd2,
    PH_ZI  = 2'd3
  } phase_t;
endpackage

// File: rtl/dss_cmp_sync.sv
module dss_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_n = d;
    end else begin : g_many
      always_comb sh_n = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/dss_prescaler.sv
module dss_prescaler #(
  parameter int DIV = 4,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_n;

  always_comb begin
    tick  = (pre_q == LAST);
    pre_n = (clr || tick) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_n;
  end
endmodule

// File: rtl/dss_phase_ctrl.sv
module dss_phase_ctrl
  import dss_pkg::*;
#(
  parameter int DIV          = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int DEINT_MAX    = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int ZI_MIN       = 11,
  parameter int ZI_NORM      = 140,
  parameter int ZI_EXT       = 740,
  localparam int RES_W       = $clog2(DEINT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_s,
  input  logic             tick,
  output logic             pre_clr,
  output phase_t           phase,
  output logic [RES_W-1:0] reading,
  output logic             negative,
  output logic             overrange,
  output logic             valid
);
  localparam int CYC_CLKS = CYCLE_COUNTS * DIV;
  localparam int CYC_W    = $clog2(CYC_CLKS);
  localparam int CNT_MAX  = (INT_COUNTS > DEINT_MAX) ? INT_COUNTS : DEINT_MAX;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int ZC_W     = $clog2(ZI_EXT + 1);

  localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(CYC_CLKS - 1);
  localparam logic [CNT_W-1:0] INT_LAST  = CNT_W'(INT_COUNTS - 1);
  localparam logic [CNT_W-1:0] DI_LAST   = CNT_W'(DEINT_MAX - 1);
  localparam logic [RES_W-1:0] DI_FULL   = RES_W'(DEINT_MAX);
  localparam logic [ZC_W-1:0]  ZN_LAST   = ZC_W'(ZI_NORM - 1);
  localparam logic [ZC_W-1:0]  ZE_LAST   = ZC_W'(ZI_EXT - 1);
  localparam logic [ZC_W-1:0]  ZMIN_LAST = ZC_W'(ZI_MIN - 1);

  phase_t             phase_q, phase_n;
  logic [CYC_W-1:0]   cyc_q, cyc_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [ZC_W-1:0]    zc_q, zc_n;
  logic               pos_q, pos_n;
  logic               cmp_d;
  logic [RES_W-1:0]   res_q, res_n;
  logic               neg_q, neg_n;
  logic               ovf_q, ovf_n;
  logic               vld_q, vld_n;
  logic               chg;
  logic [ZC_W-1:0]    zlast;

  always_comb begin
    phase_n = phase_q;
    cyc_n   = (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
    cnt_n   = tick ? cnt_q + 1'b1 : cnt_q;
    zc_n    = zc_q;
    pos_n   = pos_q;
    res_n   = res_q;
    neg_n   = neg_q;
    ovf_n   = ovf_q;
    vld_n   = 1'b0;
    pre_clr = 1'b0;
    chg     = cmp_s ^ cmp_d;
    zlast   = ovf_q ? ZE_LAST : ZN_LAST;
    unique case (phase_q)
      PH_AZ: begin
        if (cyc_q == CYC_LAST) begin
          phase_n = PH_INT;
          cnt_n   = '0;
          pre_clr = 1'b1;
        end
      end
      PH_INT: begin
        if (tick && cnt_q == INT_LAST) begin
          phase_n = PH_DI;
          pos_n   = cmp_s;
          cnt_n   = '0;
          pre_clr = 1'b1;
        end
      end
      PH_DI: begin
        if (cmp_s != pos_q) begin
          phase_n = PH_ZI;
          res_n   = RES_W'(cnt_q);
          ovf_n   = 1'b0;
          neg_n   = ~pos_q;
          vld_n   = 1'b1;
          zc_n    = '0;
        end else if (tick && cnt_q == DI_LAST) begin
          phase_n = PH_ZI;
          res_n   = DI_FULL;
          ovf_n   = 1'b1;
          neg_n   = ~pos_q;
          vld_n   = 1'b1;
          zc_n    = '0;
        end
      end
      PH_ZI: begin
        zc_n = zc_q + 1'b1;
        if (zc_q == zlast || (!ovf_q && chg && zc_q >= ZMIN_LAST)) begin
          phase_n = PH_AZ;
        end
      end
      default: phase_n = PH_AZ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_AZ;
      cyc_q   <= '0;
      cnt_q   <= '0;
      zc_q    <= '0;
      pos_q   <= 1'b0;
      cmp_d   <= 1'b0;
      res_q   <= '0;
      neg_q   <= 1'b0;
      ovf_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cyc_q   <= cyc_n;
      cnt_q   <= cnt_n;
      zc_q    <= zc_n;
      pos_q   <= pos_n;
      cmp_d   <= cmp_s;
      res_q   <= res_n;
      neg_q   <= neg_n;
      ovf_q   <= ovf_n;
      vld_q   <= vld_n;
    end
  end

  assign phase     = phase_q;
  assign reading   = res_q;
  assign negative  = neg_q;
  assign overrange = ovf_q;
  assign valid     = vld_q;
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int DIV          = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int DEINT_MAX    = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int ZI_MIN       = 11,
  parameter int ZI_NORM      = 140,
  parameter int ZI_EXT       = 740,
  parameter int SYNC_STAGES  = 2,
  localparam int RES_W       = $clog2(DEINT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_in,
  output logic [3:0]       phase_en,
  output logic [RES_W-1:0] reading,
  output logic             negative,
  output logic             overrange,
  output logic             reading_valid
);
  logic   cmp_s;
  logic   tick;
  logic   pre_clr;
  phase_t phase;

  dss_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cmp_in),
    .q     (cmp_s)
  );

  dss_prescaler #(.DIV(DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pre_clr),
    .tick  (tick)
  );

  dss_phase_ctrl #(
    .DIV          (DIV),
    .INT_COUNTS   (INT_COUNTS),
    .DEINT_MAX    (DEINT_MAX),
    .CYCLE_COUNTS (CYCLE_COUNTS),
    .ZI_MIN       (ZI_MIN),
    .ZI_NORM      (ZI_NORM),
    .ZI_EXT       (ZI_EXT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_s     (cmp_s),
    .tick      (tick),
    .pre_clr   (pre_clr),
    .phase     (phase),
    .reading   (reading),
    .negative  (negative),
    .overrange (overrange),
    .valid     (reading_valid)
  );

  always_comb phase_en = 4'b0001 << phase;
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int DIV          = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int DEINT_MAX    = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int RES_W        = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       phase_en,
  input logic [RES_W-1:0] reading,
  input logic             negative,
  input logic             overrange,
  input logic             reading_valid
);
  localparam logic [31:0] INT_CLKS = 32'(INT_COUNTS * DIV);
  localparam logic [31:0] CYC_CLKS = 32'(CYCLE_COUNTS * DIV);

  logic [31:0] int_len;
  logic [31:0] cyc_len;
  logic        int_d;
  logic        seen;
  logic        int_rise;

  assign int_rise = phase_en[1] & ~int_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_len <= '0;
      cyc_len <= '0;
      int_d   <= 1'b0;
      seen    <= 1'b0;
    end else begin
      int_len <= phase_en[1] ? int_len + 1 : '0;
      cyc_len <= int_rise ? 32'd1 : cyc_len + 1;
      int_d   <= phase_en[1];
      seen    <= seen | int_rise;
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(phase_en));

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_en) |-> phase_en == {$past(phase_en[2:0]), $past(phase_en[3])});

  p_int_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_en[1]) |-> int_len == INT_CLKS);

  p_over_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrange |-> reading == RES_W'(DEINT_MAX));

  p_valid_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reading_valid |=> !reading_valid);

  p_valid_zi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reading_valid |-> phase_en[3] && $past(phase_en[2]));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reading_valid |-> $stable(reading) && $stable(negative) && $stable(overrange));

  p_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rise && seen) |-> cyc_len == CYC_CLKS);
endmodule

bind dual_slope_seq dss_checker #(
  .DIV          (DIV),
  .INT_COUNTS   (INT_COUNTS),
  .DEINT_MAX    (DEINT_MAX),
  .CYCLE_COUNTS (CYCLE_COUNTS),
  .RES_W        (RES_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .phase_en      (phase_en),
  .reading       (reading),
  .negative      (negative),
  .overrange     (overrange),
  .reading_valid (reading_valid)
);

// File: tb/test_dual_slope_seq.sv
module test_dual_slope_seq;
  localparam int DIV          = 4;
  localparam int INT_COUNTS   = 10;
  localparam int DEINT_MAX    = 20;
  localparam int CYCLE_COUNTS = 40;
  localparam int ZI_MIN       = 6;
  localparam int ZI_NORM      = 14;
  localparam int ZI_EXT       = 30;
  localparam int RES_W        = $clog2(DEINT_MAX + 1);
  localparam int CYC_CLKS     = CYCLE_COUNTS * DIV;

  logic             clk;
  logic             rst_n;
  logic             cmp_in;
  logic [3:0]       phase_en;
  logic [RES_W-1:0] reading;
  logic             negative;
  logic             overrange;
  logic             reading_valid;

  typedef struct {
    int rd;
    bit ng;
    bit ov;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  bit   have_last;
  int   errors;
  int   checks;
  int   ncyc;
  int   t_prev;

  dual_slope_seq #(
    .DIV(DIV), .INT_COUNTS(INT_COUNTS), .DEINT_MAX(DEINT_MAX),
    .CYCLE_COUNTS(CYCLE_COUNTS), .ZI_MIN(ZI_MIN), .ZI_NORM(ZI_NORM),
    .ZI_EXT(ZI_EXT)
  ) i_dual_slope_seq (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .phase_en(phase_en),
    .reading(reading), .negative(negative), .overrange(overrange),
    .reading_valid(reading_valid)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial begin
    ncyc = 0;
    forever begin
      @(posedge clk);
      ncyc++;
    end
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && reading_valid) begin
        if (exp_q.size() == 0) begin
          chk_eq("R7 unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk_eq("R5/R6 reading", int'(reading), e.rd);
          chk_eq("R4 negative", int'(negative), int'(e.ng));
          chk_eq("R6 overrange", int'(overrange), int'(e.ov));
          chk_eq("R7 strobe in zero-integrate", int'(phase_en), 8);
          last_exp  = e;
          have_last = 1'b1;
        end
        @(negedge clk);
        chk_eq("R7 strobe one clock", int'(reading_valid), 0);
      end
    end
  end

  task automatic check_hold();
    if (have_last) begin
      chk_eq("R7 reading held", int'(reading), last_exp.rd);
      chk_eq("R4 negative held", int'(negative), int'(last_exp.ng));
      chk_eq("R7 overrange held", int'(overrange), int'(last_exp.ov));
    end
  endtask

  task automatic run_conv(input bit cpos, input int wdi, input int wzi);
    int  n;
    bit  ov;
    int  di_exp;
    int  zi_exp;
    exp_t e;
    while (!phase_en[0]) @(negedge clk);
    check_hold();
    cmp_in = cpos;
    while (!phase_en[1]) @(negedge clk);
    if (t_prev >= 0) chk_eq("R11 cycle length", ncyc - t_prev, CYC_CLKS);
    t_prev = ncyc;
    n = 0;
    while (phase_en[1]) begin
      n++;
      @(negedge clk);
    end
    chk_eq("R3 integrate length", n, INT_COUNTS * DIV);
    ov     = (wdi < 0) || (wdi + 3 > DIV * DEINT_MAX);
    e.rd   = ov ? DEINT_MAX : (wdi + 2) / DIV;
    e.ng   = !cpos;
    e.ov   = ov;
    exp_q.push_back(e);
    di_exp = ov ? DIV * DEINT_MAX : wdi + 3;
    n = 0;
    while (phase_en[2]) begin
      if (n == wdi) cmp_in = ~cmp_in;
      n++;
      @(negedge clk);
    end
    chk_eq(ov ? "R6 de-integrate length" : "R5 de-integrate length", n, di_exp);
    if (ov) zi_exp = ZI_EXT;
    else if (wzi >= 0 && wzi + 3 >= ZI_MIN && wzi + 3 <= ZI_NORM) zi_exp = wzi + 3;
    else zi_exp = ZI_NORM;
    n = 0;
    while (phase_en[3]) begin
      if (n == wzi) cmp_in = ~cmp_in;
      n++;
      @(negedge clk);
    end
    chk_eq(ov ? "R10 zero-integrate length" :
           (wzi >= 0 ? "R9 zero-integrate length" : "R8 zero-integrate length"),
           n, zi_exp);
  endtask

  initial begin
    errors    = 0;
    checks    = 0;
    have_last = 1'b0;
    t_prev    = -1;
    cmp_in    = 1'b0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1 phase_en", int'(phase_en), 1);
    chk_eq("R1 reading", int'(reading), 0);
    chk_eq("R1 negative", int'(negative), 0);
    chk_eq("R1 overrange", int'(overrange), 0);
    chk_eq("R1 reading_valid", int'(reading_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_conv(1'b1, 18, -1);   // R5 exact count 5, R8 no crossing
    run_conv(1'b0, 37, 5);    // R5 between boundaries, R9 early exit
    run_conv(1'b1, -1, 4);    // R6 overrange, R10 toggle ignored
    run_conv(1'b0, 0, 0);     // R5 zero reading, R9 below minimum
    run_conv(1'b1, 76, 10);   // R5 near full scale, R9
    run_conv(1'b0, 77, -1);   // R5 comparator wins on last count edge
    run_conv(1'b1, 78, -1);   // R6 one clock past full scale
    run_conv(1'b0, -1, -1);   // R6 negative overrange, R10
    while (!phase_en[0]) @(negedge clk);
    repeat (5) @(negedge clk);
    check_hold();             // R4 R7 hold through following auto-zero
    chk_eq("R7 all results seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", 20000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule